// File: doc/BRIEF.md
# Deterministic Thread Store Buffer

This block lets a fixed set of hardware threads share one memory while keeping the memory contents repeatable from run to run. During a parallel phase every thread may read or write any address, but its writes are captured in a small private buffer instead of reaching memory. A load from a thread sees that thread's own buffered bytes laid over the memory value. No thread ever sees another thread's pending writes.

A thread leaves the parallel phase when its quantum expires, when it issues a synchronization operation, or when its buffer fills up. Once every thread has stopped, the buffers are drained to memory one thread after another in ascending thread index, and each buffer drains in allocation order. The pending synchronization stores are then applied in a short serial step, also in ascending thread index. After that the buffers are cleared and a new parallel round begins. The outcome is the same as committing the threads one after another, so the shared-memory result depends only on what each thread did and never on when it did it.

Requests come in one per cycle on a single port that is tagged with the thread index. The shared memory is reached through a combinational read port and a byte-masked write port.

Top module: `det_store_buffer`

## Requirements
- R1: While `inParallel` is high, `memWrEn` stays low, so stores never reach memory during the parallel phase.
- R2: An accepted load (`reqWrite`=0, `reqSync`=0) raises `rspValid` on the following cycle. `rspData` byte b (bits 8b+7..8b) then comes from the requesting thread's buffered entry for that address if that entry's mask bit b is set, and from memory otherwise. Stores buffered by other threads are never visible.
- R3: A store to an address that is already in the thread's buffer merges into that entry. Only the bytes whose `reqMask` bit is set are replaced, and no new entry is allocated.
- R4: `reqAccept` is high only when `reqValid` is high, the block is in the parallel phase, and the addressed thread has not stopped. A `quantumEnd` bit or an accepted synchronization request (`reqSync`=1) stops that thread until the round ends.
- R5: When all threads have stopped, the buffered entries are written to memory in ascending thread index, and each thread's entries in allocation order. For any byte written by several threads, the value from the highest thread index remains.
- R6: A thread whose buffer holds `BUF_DEPTH` distinct addresses is stopped, exactly as if its quantum had expired. Its further requests are rejected.
- R7: A synchronization request carries a masked store. It is applied to memory after every buffered store of the round, in ascending thread index, so it overrides buffered data at the same address.
- R8: After the serial step the buffers and synchronization slots are empty, every thread runs again, and `inParallel` returns high.
- R9: Out of reset `inParallel` is high, `rspValid` is low and `memWrEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqThread | input | TW | Requesting thread index |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSync | input | 1 | Synchronization store, applied in the serial step |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | DATA_W | Store data |
| reqMask | input | DATA_W/8 | Byte enables of a store |
| quantumEnd | input | NUM_THREADS | Per-thread quantum expiry |
| reqAccept | output | 1 | Request taken this cycle |
| rspValid | output | 1 | Load data valid |
| rspData | output | DATA_W | Load data |
| memRdAddr | output | ADDR_W | Memory read address |
| memRdData | input | DATA_W | Memory read data, combinational |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W | Memory write address |
| memWrData | output | DATA_W | Memory write data |
| memWrMask | output | DATA_W/8 | Memory byte enables |
| inParallel | output | 1 | Parallel phase active |

## Verification
The assertions assume that the memory answers a read combinationally in the same cycle, and that nothing outside the block writes memory while a round is in progress. They also assume that a request and a `quantumEnd` for the same thread are not raised in the same cycle. The stimulus issues at most one request per cycle from the negative edge, keeps its address range small so that buffer hits and full buffers happen often, and pulses `quantumEnd` only in cycles with no request. Its bench memory is the only writer of the memory contents.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    PH_PAR    = 2'd0,
    PH_COMMIT = 2'd1,
    PH_SYNC   = 2'd2
  } sbPhase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // accepted ordinary store
    logic load;      // accepted load
    logic syncRec;   // accepted synchronization store
    logic drainEn;   // write selected buffer entry to memory
    logic syncEn;    // write selected sync slot to memory
    logic clearAll;  // empty every buffer at round end
  } sbStrobe_t;

endpackage

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int BUF_DEPTH   = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  localparam int NB = DATA_W / 8,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int EW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sbStrobe_t                     strb,
  input  logic [TW-1:0]                 reqThread,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqData,
  input  logic [NB-1:0]                 reqMask,
  input  logic [TW-1:0]                 selThread,
  input  logic [EW-1:0]                 selEntry,
  output logic [NUM_THREADS-1:0]        bufFull,
  output logic [NUM_THREADS-1:0][CW-1:0] entCount,
  output logic [NUM_THREADS-1:0]        syncValid,
  output logic                          rspValid,
  output logic [DATA_W-1:0]             rspData,
  output logic [ADDR_W-1:0]             memRdAddr,
  input  logic [DATA_W-1:0]             memRdData,
  output logic                          memWrEn,
  output logic [ADDR_W-1:0]             memWrAddr,
  output logic [DATA_W-1:0]             memWrData,
  output logic [NB-1:0]                 memWrMask
);

  logic [ADDR_W-1:0] entAddr [NUM_THREADS][BUF_DEPTH];
  logic [DATA_W-1:0] entData [NUM_THREADS][BUF_DEPTH];
  logic [NB-1:0]     entMask [NUM_THREADS][BUF_DEPTH];

  logic [ADDR_W-1:0] syncAddr [NUM_THREADS];
  logic [DATA_W-1:0] syncData [NUM_THREADS];
  logic [NB-1:0]     syncMask [NUM_THREADS];

  logic              hit;
  logic [EW-1:0]     hitIdx;
  logic [EW-1:0]     wrIdx;
  logic [DATA_W-1:0] mergedData;
  logic [NB-1:0]     mergedMask;
  logic [DATA_W-1:0] loadData;

  // lookup in the requesting thread's buffer
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int e = 0; e < BUF_DEPTH; e++) begin
      if (!hit && (CW'(e) < entCount[reqThread]) && (entAddr[reqThread][e] == reqAddr)) begin
        hit    = 1'b1;
        hitIdx = EW'(e);
      end
    end
  end

  // store merge under byte mask
  always_comb begin
    mergedData = hit ? entData[reqThread][hitIdx] : '0;
    mergedMask = hit ? (entMask[reqThread][hitIdx] | reqMask) : reqMask;
    for (int b = 0; b < NB; b++) begin
      if (reqMask[b]) mergedData[b*8 +: 8] = reqData[b*8 +: 8];
    end
    wrIdx = hit ? hitIdx : entCount[reqThread][EW-1:0];
  end

  // load: own buffered bytes over memory bytes
  assign memRdAddr = reqAddr;
  always_comb begin
    loadData = memRdData;
    for (int b = 0; b < NB; b++) begin
      if (hit && entMask[reqThread][hitIdx][b]) loadData[b*8 +: 8] = entData[reqThread][hitIdx][b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.load;
      if (strb.load) rspData <= loadData;
    end
  end

  // occupancy and sync slot valid bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entCount  <= '0;
      syncValid <= '0;
    end else if (strb.clearAll) begin
      entCount  <= '0;
      syncValid <= '0;
    end else begin
      if (strb.capture && !hit) entCount[reqThread] <= entCount[reqThread] + CW'(1);
      if (strb.syncRec) syncValid[reqThread] <= 1'b1;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (strb.capture) begin
      entAddr[reqThread][wrIdx] <= reqAddr;
      entData[reqThread][wrIdx] <= mergedData;
      entMask[reqThread][wrIdx] <= mergedMask;
    end
    if (strb.syncRec) begin
      syncAddr[reqThread] <= reqAddr;
      syncData[reqThread] <= reqData;
      syncMask[reqThread] <= reqMask;
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_full
    assign bufFull[t] = (entCount[t] == CW'(BUF_DEPTH));
  end

  // drain port
  assign memWrEn   = strb.drainEn | strb.syncEn;
  assign memWrAddr = strb.drainEn ? entAddr[selThread][selEntry] : syncAddr[selThread];
  assign memWrData = strb.drainEn ? entData[selThread][selEntry] : syncData[selThread];
  assign memWrMask = strb.drainEn ? entMask[selThread][selEntry] : syncMask[selThread];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !hit) |-> (entCount[reqThread] < CW'(BUF_DEPTH))); // R6

  AST_BUF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (entCount == '0 && syncValid == '0)); // R8

  AST_NO_WRITE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture || strb.load) |-> !memWrEn); // R1

endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int BUF_DEPTH   = 4,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int EW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [TW-1:0]                  reqThread,
  input  logic                           reqWrite,
  input  logic                           reqSync,
  input  logic [NUM_THREADS-1:0]         quantumEnd,
  input  logic [NUM_THREADS-1:0]         bufFull,
  input  logic [NUM_THREADS-1:0][CW-1:0] entCount,
  input  logic [NUM_THREADS-1:0]         syncValid,
  output sbStrobe_t                      strb,
  output logic [TW-1:0]                  selThread,
  output logic [EW-1:0]                  selEntry,
  output logic                           reqAccept,
  output logic                           inParallel
);

  localparam logic [TW-1:0] LAST_THR = TW'(NUM_THREADS - 1);

  sbPhase_t                phase;
  logic [TW-1:0]           thrPtr;
  logic [CW-1:0]           entPtr;
  logic [NUM_THREADS-1:0]  stopped;
  logic [NUM_THREADS-1:0]  blocked;
  logic [NUM_THREADS-1:0]  syncStop;
  logic                    entLeft;

  assign blocked    = stopped | bufFull;
  assign entLeft    = (entPtr < entCount[thrPtr]);
  assign inParallel = (phase == PH_PAR);
  assign selThread  = thrPtr;
  assign selEntry   = entPtr[EW-1:0];
  assign reqAccept  = reqValid && (phase == PH_PAR) && !blocked[reqThread];
  assign syncStop   = strb.syncRec ? (NUM_THREADS'(1) << reqThread) : '0;

  always_comb begin
    strb          = '0;
    strb.capture  = reqAccept && reqWrite && !reqSync;
    strb.load     = reqAccept && !reqWrite && !reqSync;
    strb.syncRec  = reqAccept && reqSync;
    unique case (phase)
      PH_COMMIT: strb.drainEn = entLeft;
      PH_SYNC: begin
        strb.syncEn   = syncValid[thrPtr];
        strb.clearAll = (thrPtr == LAST_THR);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_PAR;
      thrPtr  <= '0;
      entPtr  <= '0;
      stopped <= '0;
    end else begin
      unique case (phase)
        PH_PAR: begin
          stopped <= stopped | bufFull | quantumEnd | syncStop;
          if (&blocked) begin
            phase  <= PH_COMMIT;
            thrPtr <= '0;
            entPtr <= '0;
          end
        end
        PH_COMMIT: begin
          if (entLeft) begin
            entPtr <= entPtr + CW'(1);
          end else if (thrPtr == LAST_THR) begin
            phase  <= PH_SYNC;
            thrPtr <= '0;
          end else begin
            thrPtr <= thrPtr + TW'(1);
            entPtr <= '0;
          end
        end
        PH_SYNC: begin
          if (thrPtr == LAST_THR) begin
            phase   <= PH_PAR;
            thrPtr  <= '0;
            stopped <= '0;
          end else begin
            thrPtr <= thrPtr + TW'(1);
          end
        end
        default: phase <= PH_PAR;
      endcase
    end
  end

  AST_COMMIT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COMMIT && $past(phase) == PH_COMMIT) |-> (thrPtr >= $past(thrPtr))); // R5

  AST_ROUND_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PAR && $past(phase) == PH_SYNC) |-> (stopped == '0)); // R8

  AST_SYNC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SYNC) |=> (phase != PH_COMMIT)); // R7

endmodule

// File: rtl/det_store_buffer.sv
module det_store_buffer
  import sb_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int BUF_DEPTH   = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  localparam int NB = DATA_W / 8,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int EW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [TW-1:0]          reqThread,
  input  logic                   reqWrite,
  input  logic                   reqSync,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqData,
  input  logic [NB-1:0]          reqMask,
  input  logic [NUM_THREADS-1:0] quantumEnd,
  output logic                   reqAccept,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspData,
  output logic [ADDR_W-1:0]      memRdAddr,
  input  logic [DATA_W-1:0]      memRdData,
  output logic                   memWrEn,
  output logic [ADDR_W-1:0]      memWrAddr,
  output logic [DATA_W-1:0]      memWrData,
  output logic [NB-1:0]          memWrMask,
  output logic                   inParallel
);

  sbStrobe_t                      strb;
  logic [TW-1:0]                  selThread;
  logic [EW-1:0]                  selEntry;
  logic [NUM_THREADS-1:0]         bufFull;
  logic [NUM_THREADS-1:0][CW-1:0] entCount;
  logic [NUM_THREADS-1:0]         syncValid;

  sb_control #(
    .NUM_THREADS(NUM_THREADS),
    .BUF_DEPTH  (BUF_DEPTH)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqThread (reqThread),
    .reqWrite  (reqWrite),
    .reqSync   (reqSync),
    .quantumEnd(quantumEnd),
    .bufFull   (bufFull),
    .entCount  (entCount),
    .syncValid (syncValid),
    .strb      (strb),
    .selThread (selThread),
    .selEntry  (selEntry),
    .reqAccept (reqAccept),
    .inParallel(inParallel)
  );

  sb_datapath #(
    .NUM_THREADS(NUM_THREADS),
    .BUF_DEPTH  (BUF_DEPTH),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqThread(reqThread),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqMask  (reqMask),
    .selThread(selThread),
    .selEntry (selEntry),
    .bufFull  (bufFull),
    .entCount (entCount),
    .syncValid(syncValid),
    .rspValid (rspValid),
    .rspData  (rspData),
    .memRdAddr(memRdAddr),
    .memRdData(memRdData),
    .memWrEn  (memWrEn),
    .memWrAddr(memWrAddr),
    .memWrData(memWrData),
    .memWrMask(memWrMask)
  );

endmodule

// File: tb/det_store_buffer_bench.sv
module det_store_buffer_bench;

  localparam int NT = 4;
  localparam int DEPTH = 4;
  localparam int TW = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [TW-1:0] reqThread = '0;
  logic        reqWrite = 1'b0;
  logic        reqSync = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [3:0]  reqMask = '0;
  logic [NT-1:0] quantumEnd = '0;
  logic        reqAccept, rspValid, memWrEn, inParallel;
  logic [31:0] rspData, memRdData, memWrData;
  logic [7:0]  memRdAddr, memWrAddr;
  logic [3:0]  memWrMask;

  always #2 clk = ~clk;

  det_store_buffer u_det_store_buffer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqWrite(reqWrite), .reqSync(reqSync), .reqAddr(reqAddr), .reqData(reqData),
    .reqMask(reqMask), .quantumEnd(quantumEnd), .reqAccept(reqAccept),
    .rspValid(rspValid), .rspData(rspData), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrMask(memWrMask), .inParallel(inParallel)
  );

  // bench memory
  logic [31:0] mem [256];
  logic        wEn;
  logic [7:0]  wAddr;
  logic [31:0] wData;
  logic [3:0]  wMask;
  int          parWrites = 0;
  assign memRdData = mem[memRdAddr];

  always @(negedge clk) begin
    wEn = memWrEn; wAddr = memWrAddr; wData = memWrData; wMask = memWrMask;
    if (memWrEn && inParallel) parWrites++;
  end
  always @(posedge clk) begin
    if (wEn) mem[wAddr] <= mergeBytes(mem[wAddr], wData, wMask);
  end

  // reference model
  logic [31:0] refMem [256];
  logic [7:0]  rbAddr [NT][DEPTH];
  logic [31:0] rbData [NT][DEPTH];
  logic [3:0]  rbMask [NT][DEPTH];
  int          rbCnt [NT];
  bit          running [NT];
  bit          rsValid [NT];
  logic [7:0]  rsAddr [NT];
  logic [31:0] rsData [NT];
  logic [3:0]  rsMask [NT];

  int total = 0;
  int fails = 0;

  function automatic logic [31:0] mergeBytes(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] refLoad(int t, logic [7:0] a);
    logic [31:0] v = refMem[a];
    for (int e = 0; e < rbCnt[t]; e++)
      if (rbAddr[t][e] == a) v = mergeBytes(v, rbData[t][e], rbMask[t][e]);
    return v;
  endfunction

  task automatic refStore(int t, logic [7:0] a, logic [31:0] d, logic [3:0] m);
    bit found = 0;
    for (int e = 0; e < rbCnt[t]; e++) begin
      if (rbAddr[t][e] == a) begin
        rbData[t][e] = mergeBytes(rbData[t][e], d, m);
        rbMask[t][e] = rbMask[t][e] | m;
        found = 1;
      end
    end
    if (!found) begin
      rbAddr[t][rbCnt[t]] = a; rbData[t][rbCnt[t]] = d; rbMask[t][rbCnt[t]] = m;
      rbCnt[t]++;
      if (rbCnt[t] == DEPTH) running[t] = 0;
    end
  endtask

  task automatic refCommit();
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < rbCnt[t]; e++)
        refMem[rbAddr[t][e]] = mergeBytes(refMem[rbAddr[t][e]], rbData[t][e], rbMask[t][e]);
    for (int t = 0; t < NT; t++)
      if (rsValid[t]) refMem[rsAddr[t]] = mergeBytes(refMem[rsAddr[t]], rsData[t], rsMask[t]);
    for (int t = 0; t < NT; t++) begin
      rbCnt[t] = 0; rsValid[t] = 0; running[t] = 1;
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(int t, bit wr, bit sy, logic [7:0] a, logic [31:0] d, logic [3:0] m);
    bit expAcc;
    logic [31:0] expLoad;
    @(negedge clk);
    reqValid = 1; reqThread = TW'(t); reqWrite = wr; reqSync = sy;
    reqAddr = a; reqData = d; reqMask = m;
    #1;
    expAcc = running[t];
    expLoad = refLoad(t, a);
    if (rbCnt[t] == DEPTH) check(reqAccept == expAcc, "R6", "accept on full buffer", 32'(reqAccept), 32'(expAcc));
    else check(reqAccept == expAcc, "R4", "accept", 32'(reqAccept), 32'(expAcc));
    @(negedge clk);
    reqValid = 0;
    check(rspValid == (expAcc && !wr && !sy), "R2", "rspValid", 32'(rspValid), 32'(expAcc && !wr && !sy));
    if (expAcc && !wr && !sy) check(rspData == expLoad, "R2", "load data", rspData, expLoad);
    if (expAcc) begin
      if (sy) begin
        rsValid[t] = 1; rsAddr[t] = a; rsData[t] = d; rsMask[t] = m; running[t] = 0;
      end else if (wr) begin
        refStore(t, a, d, m);
      end
    end
  endtask

  task automatic stopThreads(logic [NT-1:0] which);
    @(negedge clk);
    quantumEnd = which;
    @(negedge clk);
    quantumEnd = '0;
    for (int t = 0; t < NT; t++) if (which[t]) running[t] = 0;
  endtask

  task automatic endRound();
    int mism = 0;
    int firstA = 0;
    int guard = 0;
    stopThreads('1);
    while (inParallel && guard < 100) begin @(negedge clk); guard++; end
    guard = 0;
    while (!inParallel && guard < 300) begin @(negedge clk); guard++; end
    check(inParallel == 1'b1, "R8", "round returns to parallel", 32'(inParallel), 32'd1);
    refCommit();
    for (int a = 0; a < 64; a++) begin
      if (mem[a] !== refMem[a]) begin
        if (mism == 0) firstA = a;
        mism++;
      end
    end
    check(mism == 0, "R5", "memory after commit", mem[firstA], refMem[firstA]);
    check(parWrites == 0, "R1", "writes during parallel phase", 32'(parWrites), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int a = 0; a < 256; a++) begin
      mem[a] = 32'(a) * 32'h0101_0101 ^ 32'hC3A5_0000;
      refMem[a] = mem[a];
    end
    for (int t = 0; t < NT; t++) begin
      rbCnt[t] = 0; rsValid[t] = 0; running[t] = 1;
    end
    repeat (3) @(negedge clk);
    check(inParallel == 1'b1, "R9", "reset inParallel", 32'(inParallel), 32'd1);
    check(rspValid == 1'b0, "R9", "reset rspValid", 32'(rspValid), 32'd0);
    check(memWrEn == 1'b0, "R9", "reset memWrEn", 32'(memWrEn), 32'd0);
    rstN = 1;
    @(negedge clk);

    // R3: repeated stores to one address merge into a single entry
    issue(0, 1, 0, 8'd40, 32'h1111_1111, 4'b0001);
    issue(0, 1, 0, 8'd40, 32'h2222_2222, 4'b0010);
    issue(0, 1, 0, 8'd40, 32'h3333_3333, 4'b0100);
    issue(0, 1, 0, 8'd40, 32'h4444_4444, 4'b0001);
    issue(0, 1, 0, 8'd40, 32'h5555_5555, 4'b0010);
    issue(0, 1, 0, 8'd40, 32'h6666_6666, 4'b0000);
    check(running[0] == 1, "R3", "thread still running after merges", 32'(running[0]), 32'd1);
    issue(0, 1, 0, 8'd43, 32'h7777_7777, 4'b1111); // R3 still accepted: entry count 1
    issue(0, 0, 0, 8'd40, 32'h0, 4'h0);           // R2 merged view
    issue(1, 0, 0, 8'd40, 32'h0, 4'h0);           // R2 other thread sees memory
    endRound();

    // R5 / R7: overlapping writers, sync overrides
    issue(0, 1, 0, 8'd41, 32'hA0A0_A0A0, 4'b1111);
    issue(1, 1, 0, 8'd41, 32'hB1B1_B1B1, 4'b1111);
    issue(2, 1, 0, 8'd41, 32'hC2C2_C2C2, 4'b0011);
    issue(3, 1, 0, 8'd41, 32'hD3D3_D3D3, 4'b1000);
    issue(3, 1, 0, 8'd42, 32'hE4E4_E4E4, 4'b1111);
    issue(2, 1, 1, 8'd42, 32'h9999_8888, 4'b1111);
    issue(2, 1, 0, 8'd44, 32'h1234_5678, 4'b1111); // R4 rejected after sync
    endRound();
    check(mem[41] == 32'hD3B1_C2C2, "R5", "highest thread wins per byte", mem[41], 32'hD3B1_C2C2);
    check(mem[42] == 32'h9999_8888, "R7", "sync after buffered stores", mem[42], 32'h9999_8888);

    // R6: fill thread 1, then it is rejected
    for (int i = 0; i < DEPTH; i++) issue(1, 1, 0, 8'(48 + i), 32'(i) * 32'h1010_1010, 4'b1111);
    check(running[1] == 0, "R6", "model marks full", 32'(running[1]), 32'd0);
    issue(1, 1, 0, 8'd60, 32'hDEAD_BEEF, 4'b1111);
    issue(1, 0, 0, 8'd48, 32'h0, 4'h0);
    // R4: quantum end stops one thread only
    stopThreads(4'b0100);
    issue(2, 1, 0, 8'd61, 32'hFACE_0001, 4'b1111);
    issue(0, 1, 0, 8'd61, 32'hFACE_0002, 4'b1111);
    issue(0, 0, 0, 8'd61, 32'h0, 4'h0);
    endRound();

    // constrained random rounds
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < 24; k++) begin
        int t = $urandom_range(0, NT - 1);
        int kind = $urandom_range(0, 15);
        logic [7:0] a = 8'($urandom_range(0, 15));
        logic [31:0] d = $urandom;
        logic [3:0] m = 4'($urandom_range(1, 15));
        if (kind < 7) issue(t, 0, 0, a, d, m);
        else if (kind < 15) issue(t, 1, 0, a, d, m);
        else issue(t, 1, 1, a, d, m);
      end
      endRound();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule